// File: doc/BRIEF.md
# Serial Bus Clock Stall Arbiter

This block sits beside the bus clock generator of an I3C/I2C controller and decides whether the clock must be held low at certain bit boundaries of an SDR or I2C transfer. The protocol engine raises a one-cycle phase strobe. The strobe carries the kind of bit boundary, what sort of transfer is running, whether the boundary lies mid-transfer or at the end, who ended the transfer, and the stop/response bits of the command. The block compares this context with the live occupancy flags of the data FIFOs and queues.

When a blocking condition holds at the strobe, the block raises a stall request and reports a reason code. From then on it watches only the flag behind that reason. The request drops one clock after that flag clears. A saturating counter accumulates the clock cycles spent stalled. The counter is zeroed by a clear pulse.

Top module: `clk_stall_arbiter`

## Requirements
- R1: A synchronous active-high `rst` clears the stall request, drives the reason code to 0 and zeroes the stall-cycle counter.
- R2: While `hdr_active` is high, `stall_req` is low. A strobe in that state starts no stall, and an ongoing stall is dropped at the next edge.
- R3: For a write-type kind (0 plain write, 2 broadcast CCC, 3 directed CCC write) mid-transfer, an empty TX FIFO stalls with reason 1. This applies at the ACK phase (phase 0) only when `prev_stop` is 0, and at the write parity bit (phase 1) always.
- R4: For a read-type kind (1 plain read, 4 directed CCC read) mid-transfer, a full RX FIFO stalls with reason 2. This applies at the ACK phase only when `prev_stop` is 0, and at the read transition bit (phase 2) always.
- R5: At the end of a plain write (kind 0) that the controller ended, or of a plain read (kind 1) that either side ended, with `cmd_stop` at 0 and no next command available, the block stalls with reason 3.
- R6: At the end of a transfer with `cmd_resp` at 1 that the controller ended (kind 0 or 1), a full response queue stalls with reason 4. The check in R5 takes priority.
- R7: For a directed CCC without payload (kind 5) at the ACK phase with `prev_stop` at 0, a follow-up command facing an empty command queue stalls with reason 6. Otherwise, `cmd_resp` at 1 with a full response queue stalls with reason 4.
- R8: At the IBI transition bit (phase 3), an IBI read (kind 6) or auto-command read (kind 7) with a full IBI data FIFO stalls with reason 5. Other kinds are not stalled there.
- R9: In I2C mode with a plain write at the ACK phase, an empty TX FIFO (reason 1) or else a full RX FIFO (reason 2) stalls, regardless of `prev_stop`.
- R10: Without a matching phase, kind and blocking flag at the strobe, no stall starts.
- R11: The decision is taken on the strobe cycle and the request rises at the next edge. The reason stays constant while stalled. The request falls at the first edge after the causing flag clears, and the reason is 0 when not stalled.
- R12: `stall_cycles` increments once per clock with the stall active, saturates at 65535, and returns to 0 one clock after `cnt_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_active | input | 1 | HDR mode running; stalling disabled |
| phase_valid | input | 1 | One-cycle strobe at a stall decision point |
| phase_sel | input | 2 | 0 ACK/NACK, 1 write parity, 2 read transition, 3 IBI transition |
| xfer_kind | input | 3 | 0 write, 1 read, 2 broadcast CCC, 3 directed CCC write, 4 directed CCC read, 5 directed CCC no payload, 6 IBI read, 7 auto-command read |
| i2c_mode | input | 1 | Legacy I2C transfer |
| at_end | input | 1 | Boundary is the end of the transfer |
| ctrl_ended | input | 1 | Controller (not target) ended the transfer |
| cmd_stop | input | 1 | Current command requests a stop at its end |
| cmd_resp | input | 1 | Current command requests a response |
| prev_stop | input | 1 | Previous command requested a stop |
| ccc_followup | input | 1 | Directed CCC is a follow-up, not the first |
| tx_empty | input | 1 | TX FIFO empty |
| rx_full | input | 1 | RX FIFO full |
| cmd_avail | input | 1 | Next command available |
| cmdq_empty | input | 1 | Command queue empty |
| resp_full | input | 1 | Response queue full |
| ibi_full | input | 1 | IBI data FIFO full |
| cnt_clear | input | 1 | Clears the stall-cycle counter |
| stall_req | output | 1 | Hold the bus clock low |
| stall_reason | output | 3 | 1 TX empty, 2 RX full, 3 no command, 4 response full, 5 IBI full, 6 command queue empty, 0 none |
| stall_cycles | output | 16 | Saturating count of stalled cycles |

## Verification
The decision table is exercised one strobe at a time. Each blocking row is paired with a near-identical row that must not stall: the stop bit of the previous command flipped, the terminator swapped, the follow-up flag cleared, or a wrong phase for the kind. These pairs show that each qualifier is decoded and not merely the FIFO flag. Rows with two blocking flags raised at once show the priority between reasons. Directed sequences hold a stall for a known number of cycles and compare the counter with that number. They also drive the counter into saturation, and drop HDR and reset on top of an active stall.

// File: rtl/clk_stall_arbiter.sv
module clk_stall_arbiter #(
  parameter int CNT_W = 16,
  parameter int RSN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_active,
  input  logic             phase_valid,
  input  logic [1:0]       phase_sel,
  input  logic [2:0]       xfer_kind,
  input  logic             i2c_mode,
  input  logic             at_end,
  input  logic             ctrl_ended,
  input  logic             cmd_stop,
  input  logic             cmd_resp,
  input  logic             prev_stop,
  input  logic             ccc_followup,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic             cmd_avail,
  input  logic             cmdq_empty,
  input  logic             resp_full,
  input  logic             ibi_full,
  input  logic             cnt_clear,
  output logic             stall_req,
  output logic [RSN_W-1:0] stall_reason,
  output logic [CNT_W-1:0] stall_cycles
);

  localparam logic [1:0] PH_ACK = 2'd0, PH_PAR = 2'd1, PH_RDT = 2'd2, PH_IBI = 2'd3;
  localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_BC = 3'd2, K_DW = 3'd3,
                         K_DR = 3'd4, K_NP = 3'd5, K_IB = 3'd6, K_AR = 3'd7;
  localparam logic [RSN_W-1:0] RS_NONE = 'd0, RS_TX = 'd1, RS_RX = 'd2, RS_CMD = 'd3,
                               RS_RESP = 'd4, RS_IBI = 'd5, RS_CQ = 'd6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             stall_q;
  logic [RSN_W-1:0] reason_q;
  logic [RSN_W-1:0] cand;
  logic             hold;
  logic             is_wr, is_rd;

  assign is_wr = (xfer_kind == K_WR) || (xfer_kind == K_BC) || (xfer_kind == K_DW);
  assign is_rd = (xfer_kind == K_RD) || (xfer_kind == K_DR);

  always_comb begin
    cand = RS_NONE;
    if (at_end) begin
      if (phase_sel != PH_IBI) begin
        if (xfer_kind == K_WR && ctrl_ended) begin
          if (!cmd_stop && !cmd_avail)      cand = RS_CMD;
          else if (cmd_resp && resp_full)   cand = RS_RESP;
        end else if (xfer_kind == K_RD) begin
          if (!cmd_stop && !cmd_avail)                    cand = RS_CMD;
          else if (cmd_resp && ctrl_ended && resp_full)   cand = RS_RESP;
        end
      end
    end else begin
      case (phase_sel)
        PH_ACK: begin
          if (i2c_mode && xfer_kind == K_WR) begin
            if (tx_empty)     cand = RS_TX;
            else if (rx_full) cand = RS_RX;
          end else if (!prev_stop) begin
            if (is_wr && tx_empty)      cand = RS_TX;
            else if (is_rd && rx_full)  cand = RS_RX;
            else if (xfer_kind == K_NP) begin
              if (ccc_followup && cmdq_empty) cand = RS_CQ;
              else if (cmd_resp && resp_full) cand = RS_RESP;
            end
          end
        end
        PH_PAR:  if (is_wr && tx_empty) cand = RS_TX;
        PH_RDT:  if (is_rd && rx_full)  cand = RS_RX;
        default: if ((xfer_kind == K_IB || xfer_kind == K_AR) && ibi_full) cand = RS_IBI;
      endcase
    end
  end

  always_comb begin
    case (reason_q)
      RS_TX:   hold = tx_empty;
      RS_RX:   hold = rx_full;
      RS_CMD:  hold = !cmd_avail;
      RS_RESP: hold = resp_full;
      RS_IBI:  hold = ibi_full;
      RS_CQ:   hold = cmdq_empty;
      default: hold = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || hdr_active) begin
      stall_q  <= 1'b0;
      reason_q <= RS_NONE;
    end else if (stall_q) begin
      if (!hold) begin
        stall_q  <= 1'b0;
        reason_q <= RS_NONE;
      end
    end else if (phase_valid && cand != RS_NONE) begin
      stall_q  <= 1'b1;
      reason_q <= cand;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clear)                       stall_cycles <= '0;
    else if (stall_q && stall_cycles != CNT_MAX) stall_cycles <= stall_cycles + 1'b1;
  end

  assign stall_req    = stall_q && !hdr_active;
  assign stall_reason = stall_req ? reason_q : RS_NONE;

  // R2
  hdr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_active |=> !stall_q);

  // R10
  start_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_q) |-> $past(phase_valid));

  // R11
  reason_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_q && $past(stall_q)) |-> $stable(reason_q));

  // R8
  ibi_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_q && reason_q == RS_IBI) |-> $past(ibi_full));

  // R12
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_clear |=> stall_cycles >= $past(stall_cycles));

endmodule

// File: tb/clk_stall_arbiter_bench.sv
module clk_stall_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic clk = 1'b0;
  logic rst, hdr_active, phase_valid, i2c_mode, at_end, ctrl_ended;
  logic cmd_stop, cmd_resp, prev_stop, ccc_followup;
  logic tx_empty, rx_full, cmd_avail, cmdq_empty, resp_full, ibi_full, cnt_clear;
  logic [1:0] phase_sel;
  logic [2:0] xfer_kind;
  logic stall_req;
  logic [2:0] stall_reason;
  logic [15:0] stall_cycles;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_stall_arbiter u_clk_stall_arbiter (
    .clk(clk), .rst(rst), .hdr_active(hdr_active), .phase_valid(phase_valid),
    .phase_sel(phase_sel), .xfer_kind(xfer_kind), .i2c_mode(i2c_mode),
    .at_end(at_end), .ctrl_ended(ctrl_ended), .cmd_stop(cmd_stop), .cmd_resp(cmd_resp),
    .prev_stop(prev_stop), .ccc_followup(ccc_followup), .tx_empty(tx_empty),
    .rx_full(rx_full), .cmd_avail(cmd_avail), .cmdq_empty(cmdq_empty),
    .resp_full(resp_full), .ibi_full(ibi_full), .cnt_clear(cnt_clear),
    .stall_req(stall_req), .stall_reason(stall_reason), .stall_cycles(stall_cycles)
  );

  // {req, hdr, phase, kind, ctl[i2c end ctrl stop resp prevstop followup], flags[tx rx avail cq rf ibi], exp}
  localparam logic [25:0] VEC [NVEC] = '{
    {4'd3,  1'b0, 2'd0, 3'd0, 7'b0000000, 6'b101000, 3'd1}, // R3 ack write
    {4'd3,  1'b0, 2'd1, 3'd2, 7'b0000000, 6'b101000, 3'd1}, // R3 parity broadcast
    {4'd3,  1'b0, 2'd1, 3'd3, 7'b0000000, 6'b101000, 3'd1}, // R3 parity directed write
    {4'd3,  1'b0, 2'd0, 3'd0, 7'b0000010, 6'b101000, 3'd0}, // R3 prev stop blocks
    {4'd4,  1'b0, 2'd2, 3'd1, 7'b0000000, 6'b011000, 3'd2}, // R4 read transition
    {4'd4,  1'b0, 2'd0, 3'd4, 7'b0000000, 6'b011000, 3'd2}, // R4 ack directed read
    {4'd4,  1'b0, 2'd0, 3'd1, 7'b0000010, 6'b011000, 3'd0}, // R4 prev stop blocks
    {4'd5,  1'b0, 2'd1, 3'd0, 7'b0110000, 6'b000000, 3'd3}, // R5 write end by controller
    {4'd5,  1'b0, 2'd1, 3'd0, 7'b0100000, 6'b000000, 3'd0}, // R5 write end by target
    {4'd5,  1'b0, 2'd2, 3'd1, 7'b0100000, 6'b000000, 3'd3}, // R5 read end by target
    {4'd5,  1'b0, 2'd2, 3'd1, 7'b0101000, 6'b000000, 3'd0}, // R5 stop set
    {4'd6,  1'b0, 2'd1, 3'd0, 7'b0111100, 6'b001010, 3'd4}, // R6 response full
    {4'd6,  1'b0, 2'd2, 3'd1, 7'b0101100, 6'b001010, 3'd0}, // R6 target ended
    {4'd6,  1'b0, 2'd1, 3'd0, 7'b0110100, 6'b000010, 3'd3}, // R6 R5 has priority
    {4'd7,  1'b0, 2'd0, 3'd5, 7'b0000001, 6'b001100, 3'd6}, // R7 follow-up cq empty
    {4'd7,  1'b0, 2'd0, 3'd5, 7'b0000000, 6'b001100, 3'd0}, // R7 first command
    {4'd7,  1'b0, 2'd0, 3'd5, 7'b0000100, 6'b001010, 3'd4}, // R7 response full
    {4'd7,  1'b0, 2'd0, 3'd5, 7'b0000011, 6'b001100, 3'd0}, // R7 prev stop blocks
    {4'd8,  1'b0, 2'd3, 3'd6, 7'b0000000, 6'b001001, 3'd5}, // R8 IBI read
    {4'd8,  1'b0, 2'd3, 3'd7, 7'b0000000, 6'b001001, 3'd5}, // R8 auto-command read
    {4'd8,  1'b0, 2'd3, 3'd0, 7'b0000000, 6'b001001, 3'd0}, // R8 other kind
    {4'd9,  1'b0, 2'd0, 3'd0, 7'b1000010, 6'b011000, 3'd2}, // R9 i2c rx full
    {4'd9,  1'b0, 2'd0, 3'd0, 7'b1000000, 6'b111000, 3'd1}, // R9 i2c tx first
    {4'd10, 1'b0, 2'd2, 3'd0, 7'b0000000, 6'b111000, 3'd0}, // R10 wrong phase
    {4'd2,  1'b1, 2'd0, 3'd0, 7'b0000000, 6'b101000, 3'd0}, // R2 hdr
    {4'd10, 1'b0, 2'd0, 3'd0, 7'b0000000, 6'b001000, 3'd0}  // R10 nothing blocking
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    hdr_active = 0; phase_valid = 0; phase_sel = 0; xfer_kind = 0; i2c_mode = 0;
    at_end = 0; ctrl_ended = 0; cmd_stop = 0; cmd_resp = 0; prev_stop = 0;
    ccc_followup = 0; tx_empty = 0; rx_full = 0; cmd_avail = 1; cmdq_empty = 0;
    resp_full = 0; ibi_full = 0; cnt_clear = 0;
  endtask

  task automatic strobe_tx_stall();
    @(negedge clk);
    phase_sel = 2'd1; xfer_kind = 3'd0; tx_empty = 1; phase_valid = 1;
    @(negedge clk);
    phase_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, 16'(stall_req), 16'd0, "stall after reset");
    check(1, 16'(stall_reason), 16'd0, "reason after reset");
    check(1, stall_cycles, 16'd0, "counter after reset");
    rst = 0;

    for (int i = 0; i < NVEC; i++) begin
      logic [25:0] v;
      v = VEC[i];
      @(negedge clk);
      hdr_active = v[21]; phase_sel = v[20:19]; xfer_kind = v[18:16];
      {i2c_mode, at_end, ctrl_ended, cmd_stop, cmd_resp, prev_stop, ccc_followup} = v[15:9];
      {tx_empty, rx_full, cmd_avail, cmdq_empty, resp_full, ibi_full} = v[8:3];
      phase_valid = 1;
      @(negedge clk);
      phase_valid = 0;
      check(int'(v[25:22]), 16'(stall_reason), 16'(v[2:0]), $sformatf("vector %0d reason", i));
      check(int'(v[25:22]), 16'(stall_req), 16'(v[2:0] != 3'd0), $sformatf("vector %0d stall", i));
      idle_inputs();
      @(negedge clk);
      // R11 release one edge after the flag clears
      check(11, 16'(stall_req), 16'd0, $sformatf("vector %0d release", i));
    end

    // R11 hold and R12 exact count
    @(negedge clk); cnt_clear = 1; @(negedge clk); cnt_clear = 0;
    strobe_tx_stall();
    repeat (4) begin
      check(11, 16'(stall_req), 16'd1, "stall held");
      check(11, 16'(stall_reason), 16'd1, "reason held");
      @(negedge clk);
    end
    tx_empty = 0;
    @(negedge clk);
    check(11, 16'(stall_req), 16'd0, "release after hold");
    check(11, 16'(stall_reason), 16'd0, "reason after release");
    check(12, stall_cycles, 16'd5, "stalled cycle count");

    // R12 clear
    cnt_clear = 1; @(negedge clk); cnt_clear = 0;
    check(12, stall_cycles, 16'd0, "counter cleared");

    // R2 hdr drops an ongoing stall
    strobe_tx_stall();
    check(2, 16'(stall_req), 16'd1, "stall before hdr");
    hdr_active = 1;
    #1;
    check(2, 16'(stall_req), 16'd0, "hdr masks stall");
    @(negedge clk);
    hdr_active = 0;
    #1;
    check(2, 16'(stall_req), 16'd0, "stall gone after hdr");
    idle_inputs();

    // R1 reset on top of a stall
    strobe_tx_stall();
    rst = 1; @(negedge clk); rst = 0;
    check(1, 16'(stall_req), 16'd0, "reset drops stall");
    check(1, stall_cycles, 16'd0, "reset zeroes counter");
    idle_inputs();

    // R12 saturation
    strobe_tx_stall();
    repeat (70000) @(negedge clk);
    check(12, stall_cycles, 16'hFFFF, "counter saturates");
    check(11, 16'(stall_req), 16'd1, "long stall held");
    tx_empty = 0;
    @(negedge clk);
    check(12, stall_cycles, 16'hFFFF, "saturated after release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule